// File: doc/BRIEF.md
# Timer Clock Select and Divider

This block produces the count-enable strobe for a PWM timer. The strobe comes from one of two sources: the slow instruction-clock enable, or a fast enable derived from an on-chip PLL. When the fast source is used, the block divides it by 1, 2, 4 or 8. Both sources arrive as single-cycle enable pulses in the block's own clock domain. The PLL itself is not modelled; only its lock indication enters the block.

Software controls the block through one 8-bit control register. It holds a PLL-enable bit, a source-select bit and a 2-bit divide-select field. While the timer runs, the PLL-enable and source bits are write-protected. A new divide selection can be written at any time, but it is held in a shadow copy. It becomes active only when the timer reports an overflow, so a PWM cycle never changes rate partway through. When the timer is stopped, a new divide selection is active from the cycle after the write.

Top module: `timer_clk_gen`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00: the PLL is disabled, the instruction clock is the source, and the divide is 1.
- R2: Bit 7 enables the PLL. A write made while `run_mode` is high leaves bit 7 unchanged.
- R3: Bit 4 selects the source (1 = PLL-derived fast clock, 0 = instruction clock). A write made while `run_mode` is high leaves bit 4 unchanged.
- R4: Bits 6:5 hold the divide selection. Every write updates them, including writes made in run mode, and readback always returns the last value written.
- R5: A divide selection of 0, 1, 2 or 3 gives one `tick_en` pulse for every 1, 2, 4 or 8 `fast_tick` pulses. The count starts from the moment the selection becomes active, so the first pulse falls on the Nth fast tick.
- R6: While `run_mode` is high, the active divide changes only in a cycle with `tmr_ovf` high. At that point it takes the stored bits 6:5 as they stood in that cycle, and the divider count restarts.
- R7: While `run_mode` is low, a write makes its divide selection active from the next cycle and restarts the divider count.
- R8: With bit 4 low, `tick_en` equals `instr_tick` in every cycle.
- R9: With bit 4 high, `tick_en` stays low whenever bit 7 is low or `pll_lock` is low.
- R10: Bits 3:0 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| run_mode | input | 1 | Timer is running |
| tmr_ovf | input | 1 | Single-cycle timer overflow pulse |
| pll_lock | input | 1 | PLL reports lock |
| fast_tick | input | 1 | Undivided PLL-derived enable pulse |
| instr_tick | input | 1 | Instruction-clock enable pulse |
| tick_en | output | 1 | Timer count-enable strobe |

## Verification
The central corner case is a divide write made during run mode. If the design applied the new divide at once, the bench would see ticks at the new rate before any overflow. If it never loaded the shadow copy, the rate would stay wrong after the overflow pulse. The bench also writes all-zero data in run mode to confirm that the PLL-enable and source bits hold their values; a design without this protection would read back 0x00. The bench tests PLL gating in both failure modes (PLL disabled, and enabled but unlocked), and a design that ignored either would emit ticks.

// File: rtl/tcg_pkg.sv
// Package: shared widths and register bit positions for the timer clock block.
// Assumes an 8-bit control register and a 2-bit divide selection.
package tcg_pkg;
    localparam int REG_W     = 8;
    localparam int FS_W      = 2;
    localparam int CNT_W     = (1 << FS_W) - 1;
    localparam int BIT_PLLEN = 7;
    localparam int FS_LSB    = 5;
    localparam int BIT_SRC   = 4;
    localparam logic [REG_W-1:0] LIVE_MASK = 8'hF0;
endpackage

// File: rtl/tcg_ctrl_reg.sv
// Control register: PLL enable, source select and shadow divide selection.
// Assumes run_mode is synchronous to clk. Protected bits hold while running.
module tcg_ctrl_reg
    import tcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             run_mode,
    output logic             pll_en,
    output logic             src_pll,
    output logic [FS_W-1:0]  fs_shadow,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] wr_live;

    // Drop the reserved bits of incoming data.
    always_comb begin
        wr_live = wr_data & LIVE_MASK;
    end

    // Register update with run-mode write protection on enable and source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_en    <= 1'b0;
            src_pll   <= 1'b0;
            fs_shadow <= '0;
        end else if (wr_en) begin
            fs_shadow <= wr_live[FS_LSB +: FS_W];
            if (!run_mode) begin
                pll_en  <= wr_live[BIT_PLLEN];
                src_pll <= wr_live[BIT_SRC];
            end
        end
    end

    // Readback assembly; reserved bits read as zero.
    always_comb begin
        rd_data                 = '0;
        rd_data[BIT_PLLEN]      = pll_en;
        rd_data[FS_LSB +: FS_W] = fs_shadow;
        rd_data[BIT_SRC]        = src_pll;
    end
endmodule

// File: rtl/tcg_div_select.sv
// Active divide selection: follows writes when stopped, loads at overflow when running.
// Assumes tmr_ovf is a single-cycle pulse. Issues a load strobe to restart the divider.
module tcg_div_select
    import tcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             run_mode,
    input  logic             tmr_ovf,
    input  logic [FS_W-1:0]  fs_shadow,
    output logic [FS_W-1:0]  fs_active,
    output logic             load
);
    // Load decision for the current cycle.
    always_comb begin
        load = run_mode ? tmr_ovf : wr_en;
    end

    // Active selection register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_active <= '0;
        end else if (load) begin
            fs_active <= run_mode ? fs_shadow : wr_data[FS_LSB +: FS_W];
        end
    end
endmodule

// File: rtl/tcg_fast_div.sv
// Power-of-two divider on the fast enable. Emits a pulse on every 2**fs-th fast tick.
// Assumes load restarts the phase; the count keeps running whether or not the output is used.
module tcg_fast_div
    import tcg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            fast_tick,
    input  logic [FS_W-1:0] fs_active,
    output logic            div_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // One mask bit per possible divide stage.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (int'(fs_active) > i);
    end

    // Phase counter over fast ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= '0;
        end else if (fast_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Divided output pulse when the low bits of the phase are all ones.
    always_comb begin
        div_tick = fast_tick && ((cnt & mask) == mask);
    end
endmodule

// File: rtl/timer_clk_gen.sv
// Top: timer clock source select, fast-clock divider and PLL readiness gating.
// Assumes fast_tick and instr_tick are single-cycle enables in the clk domain.
module timer_clk_gen
    import tcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             run_mode,
    input  logic             tmr_ovf,
    input  logic             pll_lock,
    input  logic             fast_tick,
    input  logic             instr_tick,
    output logic             tick_en
);
    logic            pll_en;
    logic            src_pll;
    logic [FS_W-1:0] fs_shadow;
    logic [FS_W-1:0] fs_active;
    logic            load;
    logic            div_tick;

    tcg_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .run_mode(run_mode), .pll_en(pll_en), .src_pll(src_pll),
        .fs_shadow(fs_shadow), .rd_data(rd_data)
    );

    tcg_div_select u_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .run_mode(run_mode), .tmr_ovf(tmr_ovf), .fs_shadow(fs_shadow),
        .fs_active(fs_active), .load(load)
    );

    tcg_fast_div u_div (
        .clk(clk), .rst_n(rst_n), .load(load), .fast_tick(fast_tick),
        .fs_active(fs_active), .div_tick(div_tick)
    );

    // Source mux with the PLL path gated until enabled and locked.
    always_comb begin
        tick_en = src_pll ? (div_tick && pll_en && pll_lock) : instr_tick;
    end
endmodule

// File: rtl/tcg_checker.sv
// Checker: temporal properties on the ports of timer_clk_gen, attached by bind.
module tcg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       run_mode,
    input logic       pll_lock,
    input logic       instr_tick,
    input logic       tick_en
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> rd_data == 8'h00);

    assert_pll_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run_mode) |=> $stable(rd_data[7]));

    assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run_mode) |=> $stable(rd_data[4]));

    assert_fs_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[6:5] == $past(wr_data[6:5]));

    assert_instr_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |-> tick_en == instr_tick);

    assert_pll_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !(rd_data[7] && pll_lock)) |-> !tick_en);

    assert_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[3:0] == 4'h0);
endmodule

bind timer_clk_gen tcg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .run_mode(run_mode), .pll_lock(pll_lock),
    .instr_tick(instr_tick), .tick_en(tick_en)
);

// File: tb/sim_timer_clk_gen.sv
module sim_timer_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       run_mode = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       pll_lock = 1'b1;
    logic       fast_tick = 1'b0;
    logic       instr_tick = 1'b0;
    logic       tick_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // 50 MHz
    always #10 clk = ~clk;

    timer_clk_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .run_mode(run_mode), .tmr_ovf(tmr_ovf),
        .pll_lock(pll_lock), .fast_tick(fast_tick), .instr_tick(instr_tick),
        .tick_en(tick_en)
    );

    // Vector table: {register value written, ticks expected over 16 fast ticks}
    localparam logic [15:0] VEC [4] = '{
        {8'h90, 8'd16},   // R5 divide 1
        {8'hB0, 8'd8},    // R5 divide 2
        {8'hD0, 8'd4},    // R5 divide 4
        {8'hF0, 8'd2}     // R5 divide 8
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive one cycle of enables and return the sampled tick output.
    task automatic step(input logic f, input logic i, input logic o, output logic t);
        @(negedge clk);
        fast_tick = f;
        instr_tick = i;
        tmr_ovf = o;
        #1;
        t = tick_en;
        @(posedge clk);
        #1;
        fast_tick = 1'b0;
        instr_tick = 1'b0;
        tmr_ovf = 1'b0;
    endtask

    task automatic count_fast(input int n, output int c);
        logic t;
        c = 0;
        for (int k = 0; k < n; k++) begin
            step(1'b1, 1'b0, 1'b0, t);
            if (t) c++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c;
        logic t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 readback", rd_data, 8'h00);
        step(1'b1, 1'b0, 1'b0, t);
        check("R1 no tick from fast source", t, 0);

        // Table walk: divide factors, stopped timer (R5, R7)
        for (int v = 0; v < 4; v++) begin
            wr(VEC[v][15:8]);
            count_fast(16, c);
            check("R5 divide count", c, VEC[v][7:0]);
        end

        // R7: immediate change while stopped restarts phase
        wr(8'hF0);
        count_fast(3, c);
        wr(8'hD0);
        count_fast(4, c);
        check("R7 first tick on 4th fast tick", c, 1);

        // R6: deferred divide while running
        wr(8'h90);
        run_mode = 1'b1;
        wr(8'hF0);
        check("R4 readback of pending divide", rd_data, 8'hF0);
        count_fast(8, c);
        check("R6 old divide kept before overflow", c, 8);
        step(1'b0, 1'b0, 1'b1, t);
        count_fast(8, c);
        check("R6 new divide after overflow", c, 1);

        // R2/R3: protected bits while running
        wr(8'h00);
        check("R2 PLL enable held", rd_data[7], 1);
        check("R3 source held", rd_data[4], 1);
        check("R4 divide bits written in run mode", rd_data[6:5], 0);
        run_mode = 1'b0;

        // R10 reserved bits
        wr(8'h0F);
        check("R10 reserved read zero", rd_data, 8'h00);

        // R8 instruction source
        step(1'b0, 1'b1, 1'b0, t);
        check("R8 instr tick passes", t, 1);
        step(1'b1, 1'b0, 1'b0, t);
        check("R8 fast tick ignored", t, 0);

        // R9 gating
        wr(8'h10);
        count_fast(4, c);
        check("R9 PLL disabled", c, 0);
        wr(8'h90);
        pll_lock = 1'b0;
        count_fast(4, c);
        check("R9 PLL unlocked", c, 0);
        pll_lock = 1'b1;
        count_fast(4, c);
        check("R9 PLL locked ticks", c, 4);
        step(1'b0, 1'b1, 1'b0, t);
        check("R9 instr tick blocked on PLL source", t, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule